// File: doc/BRIEF.md
# Flash Suspend Arbiter

This block lets two clients share one serial flash device. A cache port issues reads. A software port issues long erase and program operations. The flash side is a simplified command interface. The arbiter starts a command with an operation code and an address, and the flash reports a done pulse for each command. It also reports a busy level while an erase or program is running and has not been suspended.

When the preemption enable is set, a read that arrives during an erase or program does not wait for it to finish. The arbiter first sends a suspend command and waits for the flash to acknowledge it. It then serves the read, or a bounded burst of reads, and sends a resume so that the long operation can continue. When the enable is clear, the two kinds of work are strictly serialized. A read is never placed directly behind a running erase or program. A short hold after each resume keeps a steady stream of reads from starving the software port.

Top module: `fsusp_arbiter`

## Requirements
- R1: After reset, fl_start, rd_gnt, pe_gnt, rd_done and pe_done are low and fl_op is 0.
- R2: With no erase or program in progress, a read request is issued as command code 1 (read) at rd_addr. rd_done then pulses with the word the flash returned.
- R3: With cfg_auto_susp high, a read arriving during an erase (code 2) or program (code 3) produces the command order: the operation, suspend (code 4), read, resume (code 5). The read completes before pe_done.
- R4: A read command is never issued while the flash reports busy with an erase or program that has not been suspended.
- R5: With cfg_auto_susp low, a read that arrives during an erase or program is issued only after pe_done. No suspend is sent.
- R6: pe_done pulses exactly once per granted operation, and only after the flash has finished the whole operation, including any suspended spans.
- R7: At most WIN_MAX reads are served in one suspend window. Further reads wait for a later window after a resume.
- R8: A suspend is issued only while the flash is busy with an erase or program.
- R9: After a resume completes, no new suspend is issued for RESUME_HOLD cycles.
- R10: When both requests arrive together while idle, the read is granted first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_auto_susp | input | 1 | 1 = preempt erase/program for reads |
| rd_req | input | 1 | Cache read request, held until rd_gnt |
| rd_addr | input | AW | Read address |
| rd_gnt | output | 1 | Read granted (one-cycle pulse) |
| rd_done | output | 1 | Read data valid (one-cycle pulse) |
| rd_data | output | DW | Read data |
| pe_req | input | 1 | Erase/program request, held until pe_gnt |
| pe_kind | input | 1 | 0 = erase, 1 = program |
| pe_addr | input | AW | Erase/program address |
| pe_wdata | input | DW | Program data |
| pe_gnt | output | 1 | Erase/program granted (pulse) |
| pe_done | output | 1 | Erase/program finished (pulse) |
| fl_start | output | 1 | Command start pulse to flash |
| fl_op | output | 3 | Command code: 1 read, 2 erase, 3 program, 4 suspend, 5 resume |
| fl_addr | output | AW | Command address |
| fl_wdata | output | DW | Program data to flash |
| fl_done | input | 1 | Flash command finished pulse |
| fl_busy | input | 1 | Flash running an unsuspended erase/program |
| fl_rdata | input | DW | Flash read data, valid with fl_done |

## Verification
A controller that loses track of whether the long operation is suspended has two visible effects. It may send a read while the flash is busy, which breaks the command order at once. Or it may forget the resume, and then pe_done never arrives and the watchdog ends the run. A window counter or hold counter that drifts shows up in the logged command order of the multi-read case within one window. A mixed-up address or data path shows up as a scoreboard mismatch on the very next read of an erased or programmed word.

// File: rtl/fsusp_pkg.sv
package fsusp_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_READ   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_PROG   = 3'd3,
    OP_SUSP   = 3'd4,
    OP_RESUME = 3'd5
  } fop_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PE_ACTIVE,
    S_SUSPENDING,
    S_READ_ACTIVE,
    S_RESUMING,
    S_SERIAL_WAIT
  } st_e;
endpackage

// File: rtl/fsusp_budget.sv
module fsusp_budget #(
  parameter int WIN_MAX     = 2,
  parameter int RESUME_HOLD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win_clr,
  input  logic rd_inc,
  input  logic hold_ld,
  output logic win_full,
  output logic hold_busy
);
  localparam int CW = $clog2(WIN_MAX + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (win_clr)     cnt_d = '0;
    else if (rd_inc) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (win_clr || rd_inc) cnt_q <= cnt_d;
  end

  assign win_full = (cnt_q >= CW'(WIN_MAX));

  AST_WINDOW_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_inc && !win_clr) |-> (cnt_q < CW'(WIN_MAX)));                    // R7

  generate
    if (RESUME_HOLD > 0) begin : g_hold
      localparam int HW = $clog2(RESUME_HOLD + 1);
      logic [HW-1:0] hold_q, hold_d;

      always_comb begin
        hold_d = hold_q;
        if (hold_ld)           hold_d = HW'(RESUME_HOLD);
        else if (hold_q != '0) hold_d = hold_q - HW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        hold_q <= '0;
        else if (hold_ld || hold_q != '0) hold_q <= hold_d;
      end

      assign hold_busy = (hold_q != '0);

      AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        win_clr |-> (hold_q == '0));                                     // R9
    end else begin : g_nohold
      assign hold_busy = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/fsusp_fsm.sv
module fsusp_fsm
  import fsusp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_auto_susp,
  input  logic rd_req,
  input  logic pe_req,
  input  logic pe_kind,
  input  logic fl_done,
  input  logic fl_busy,
  input  logic win_full,
  input  logic hold_busy,
  output logic cmd_go,
  output fop_e cmd_op,
  output logic gnt_rd,
  output logic gnt_pe,
  output logic fin_rd,
  output logic fin_pe,
  output logic win_clr,
  output logic rd_inc,
  output logic hold_ld
);
  st_e  st_q, st_d;
  logic susp_q, susp_d;

  always_comb begin
    st_d    = st_q;
    susp_d  = susp_q;
    cmd_go  = 1'b0;
    cmd_op  = OP_NONE;
    gnt_rd  = 1'b0;
    gnt_pe  = 1'b0;
    fin_rd  = 1'b0;
    fin_pe  = 1'b0;
    win_clr = 1'b0;
    rd_inc  = 1'b0;
    hold_ld = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (rd_req) begin
          cmd_go = 1'b1; cmd_op = OP_READ; gnt_rd = 1'b1;
          susp_d = 1'b0; st_d = S_READ_ACTIVE;
        end else if (pe_req) begin
          cmd_go = 1'b1; cmd_op = pe_kind ? OP_PROG : OP_ERASE;
          gnt_pe = 1'b1; st_d = S_PE_ACTIVE;
        end
      end
      S_PE_ACTIVE: begin
        if (fl_done) begin
          fin_pe = 1'b1; st_d = S_IDLE;
        end else if (rd_req) begin
          if (cfg_auto_susp && fl_busy) begin
            if (!hold_busy) begin
              cmd_go = 1'b1; cmd_op = OP_SUSP; win_clr = 1'b1;
              st_d = S_SUSPENDING;
            end
          end else begin
            st_d = S_SERIAL_WAIT;
          end
        end
      end
      S_SUSPENDING: begin
        if (fl_done) begin
          cmd_go = 1'b1; cmd_op = OP_READ; gnt_rd = 1'b1; rd_inc = 1'b1;
          susp_d = 1'b1; st_d = S_READ_ACTIVE;
        end
      end
      S_READ_ACTIVE: begin
        if (fl_done) begin
          fin_rd = 1'b1;
          if (!susp_q) begin
            st_d = S_IDLE;
          end else if (rd_req && !win_full) begin
            cmd_go = 1'b1; cmd_op = OP_READ; gnt_rd = 1'b1; rd_inc = 1'b1;
          end else begin
            cmd_go = 1'b1; cmd_op = OP_RESUME; susp_d = 1'b0;
            st_d = S_RESUMING;
          end
        end
      end
      S_RESUMING: begin
        if (fl_done) begin
          hold_ld = 1'b1; st_d = S_PE_ACTIVE;
        end
      end
      S_SERIAL_WAIT: begin
        if (fl_done) begin
          fin_pe = 1'b1; st_d = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      susp_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      susp_q <= susp_d;
    end
  end

  AST_RESUME_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RESUMING && fl_done) |=> (st_q == S_PE_ACTIVE));          // R3
endmodule

// File: rtl/fsusp_cmdout.sv
module fsusp_cmdout
  import fsusp_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_go,
  input  fop_e          cmd_op,
  input  logic          gnt_rd,
  input  logic          gnt_pe,
  input  logic          fin_rd,
  input  logic          fin_pe,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] pe_addr,
  input  logic [DW-1:0] pe_wdata,
  input  logic [DW-1:0] fl_rdata,
  output logic          fl_start,
  output logic [2:0]    fl_op,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  output logic          rd_gnt,
  output logic          pe_gnt,
  output logic          rd_done,
  output logic [DW-1:0] rd_data,
  output logic          pe_done
);
  logic [AW-1:0] pa_q, pa_d, addr_d;
  logic [DW-1:0] wd_d;

  always_comb begin
    pa_d   = gnt_pe ? pe_addr : pa_q;
    addr_d = (cmd_op == OP_READ) ? rd_addr : pa_d;
    wd_d   = gnt_pe ? pe_wdata : fl_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_start <= 1'b0;
      rd_gnt   <= 1'b0;
      pe_gnt   <= 1'b0;
      rd_done  <= 1'b0;
      pe_done  <= 1'b0;
    end else begin
      fl_start <= cmd_go;
      rd_gnt   <= gnt_rd;
      pe_gnt   <= gnt_pe;
      rd_done  <= fin_rd;
      pe_done  <= fin_pe;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_op   <= 3'd0;
      fl_addr <= '0;
      pa_q    <= '0;
    end else if (cmd_go) begin
      fl_op   <= cmd_op;
      fl_addr <= addr_d;
      pa_q    <= pa_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fl_wdata <= '0;
    else if (gnt_pe) fl_wdata <= wd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (fin_rd) rd_data <= fl_rdata;
  end
endmodule

// File: rtl/fsusp_arbiter.sv
module fsusp_arbiter
  import fsusp_pkg::*;
#(
  parameter int AW          = 24,
  parameter int DW          = 32,
  parameter int WIN_MAX     = 2,
  parameter int RESUME_HOLD = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_auto_susp,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_gnt,
  output logic          rd_done,
  output logic [DW-1:0] rd_data,
  input  logic          pe_req,
  input  logic          pe_kind,
  input  logic [AW-1:0] pe_addr,
  input  logic [DW-1:0] pe_wdata,
  output logic          pe_gnt,
  output logic          pe_done,
  output logic          fl_start,
  output logic [2:0]    fl_op,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  input  logic          fl_done,
  input  logic          fl_busy,
  input  logic [DW-1:0] fl_rdata
);
  logic [1:0] rs_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  logic cmd_go, gnt_rd, gnt_pe, fin_rd, fin_pe;
  logic win_clr, rd_inc, hold_ld, win_full, hold_busy;
  fop_e cmd_op;

  fsusp_fsm u_fsm (
    .clk(clk), .rst_n(rst_ni), .cfg_auto_susp(cfg_auto_susp),
    .rd_req(rd_req), .pe_req(pe_req), .pe_kind(pe_kind),
    .fl_done(fl_done), .fl_busy(fl_busy),
    .win_full(win_full), .hold_busy(hold_busy),
    .cmd_go(cmd_go), .cmd_op(cmd_op), .gnt_rd(gnt_rd), .gnt_pe(gnt_pe),
    .fin_rd(fin_rd), .fin_pe(fin_pe), .win_clr(win_clr), .rd_inc(rd_inc),
    .hold_ld(hold_ld)
  );

  fsusp_budget #(.WIN_MAX(WIN_MAX), .RESUME_HOLD(RESUME_HOLD)) u_budget (
    .clk(clk), .rst_n(rst_ni), .win_clr(win_clr), .rd_inc(rd_inc),
    .hold_ld(hold_ld), .win_full(win_full), .hold_busy(hold_busy)
  );

  fsusp_cmdout #(.AW(AW), .DW(DW)) u_cmd (
    .clk(clk), .rst_n(rst_ni), .cmd_go(cmd_go), .cmd_op(cmd_op),
    .gnt_rd(gnt_rd), .gnt_pe(gnt_pe), .fin_rd(fin_rd), .fin_pe(fin_pe),
    .rd_addr(rd_addr), .pe_addr(pe_addr), .pe_wdata(pe_wdata),
    .fl_rdata(fl_rdata), .fl_start(fl_start), .fl_op(fl_op),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .rd_gnt(rd_gnt),
    .pe_gnt(pe_gnt), .rd_done(rd_done), .rd_data(rd_data), .pe_done(pe_done)
  );

  AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_ni)
    (fl_start && fl_op == OP_READ) |-> !$past(fl_busy));                 // R4
  AST_SUSP_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_ni)
    (fl_start && fl_op == OP_SUSP) |-> $past(fl_busy));                  // R8
  AST_SUSP_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rst_ni)
    (fl_start && fl_op == OP_SUSP) |-> $past(cfg_auto_susp));            // R5
  AST_PE_DONE_FROM_FLASH: assert property (@(posedge clk) disable iff (!rst_ni)
    pe_done |-> $past(fl_done));                                         // R6
  AST_RD_DONE_FROM_FLASH: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_done |-> $past(fl_done));                                         // R2
  AST_GRANTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_ni)
    !(rd_gnt && pe_gnt));                                                // R10
endmodule

// File: tb/tb_fsusp_arbiter.sv
module tb_fsusp_arbiter;
  localparam int AW = 8, DW = 32, WIN_MAX = 2, HOLD = 8;
  localparam int ERASE_WORK = 60, PROG_WORK = 30;
  localparam logic [2:0] C_READ = 3'd1, C_ERASE = 3'd2, C_PROG = 3'd3,
                         C_SUSP = 3'd4, C_RES = 3'd5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cfg, rd_req, pe_req, pe_kind;
  logic [AW-1:0] rd_addr, pe_addr, fl_addr;
  logic [DW-1:0] pe_wdata, rd_data, fl_wdata, fl_rdata;
  logic rd_gnt, rd_done, pe_gnt, pe_done, fl_start, fl_done, fl_busy;
  logic [2:0] fl_op;

  fsusp_arbiter #(.AW(AW), .DW(DW), .WIN_MAX(WIN_MAX), .RESUME_HOLD(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_auto_susp(cfg),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt), .rd_done(rd_done),
    .rd_data(rd_data), .pe_req(pe_req), .pe_kind(pe_kind), .pe_addr(pe_addr),
    .pe_wdata(pe_wdata), .pe_gnt(pe_gnt), .pe_done(pe_done),
    .fl_start(fl_start), .fl_op(fl_op), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_done(fl_done), .fl_busy(fl_busy), .fl_rdata(fl_rdata)
  );

  int n_chk = 0, n_fail = 0, viol = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- flash stub ----------------
  logic [DW-1:0] fmem [16];
  logic [DW-1:0] ref_mem [16];
  logic pe_run = 0, pe_susp = 0;
  int pe_rem = 0, sh_cnt = 0;
  logic [2:0] pe_op = 0;
  logic [AW-1:0] pe_a = 0, sh_a = 0;
  logic [DW-1:0] pe_w = 0;
  logic [2:0] log_op [32];
  int log_t [32];
  int log_n = 0;

  assign fl_busy = pe_run && !pe_susp;

  initial begin
    fl_done = 0; fl_rdata = 0;
    for (int i = 0; i < 16; i++) begin
      fmem[i] = 32'hA000_0000 + i * 17;
      ref_mem[i] = 32'hA000_0000 + i * 17;
    end
  end

  always @(posedge clk) begin
    fl_done <= 1'b0;
    if (fl_start) begin
      if (log_n < 32) begin log_op[log_n] = fl_op; log_t[log_n] = cyc; log_n = log_n + 1; end
      if (sh_cnt != 0) begin viol++; $display("stub: overlapping command"); end
      case (fl_op)
        C_READ: begin
          if (pe_run && !pe_susp) begin viol++; $display("stub: read during busy"); end
          sh_cnt = 3; sh_a = fl_addr;
        end
        C_ERASE, C_PROG: begin
          pe_run = 1; pe_susp = 0; pe_op = fl_op; pe_a = fl_addr; pe_w = fl_wdata;
          pe_rem = (fl_op == C_ERASE) ? ERASE_WORK : PROG_WORK;
        end
        C_SUSP: begin
          if (!pe_run || pe_susp) begin viol++; $display("stub: bad suspend"); end
          pe_susp = 1; sh_cnt = 2;
        end
        C_RES: begin pe_susp = 0; sh_cnt = 1; end
        default: begin viol++; $display("stub: bad op"); end
      endcase
    end else begin
      if (sh_cnt == 1) begin
        fl_done <= 1'b1; fl_rdata <= fmem[sh_a[3:0]]; sh_cnt = 0;
      end else if (sh_cnt > 1) sh_cnt = sh_cnt - 1;
      if (pe_run && !pe_susp) begin
        if (pe_rem == 1) begin
          fmem[pe_a[3:0]] = (pe_op == C_ERASE) ? '1 : pe_w;
          pe_run = 0; fl_done <= 1'b1;
        end else pe_rem = pe_rem - 1;
      end
    end
  end

  // ---------------- scoreboard ----------------
  logic [DW-1:0] exp_q [$];
  int pe_cnt = 0, t_rd = 0, t_pe = 0;
  logic pend_kind = 0;
  logic [AW-1:0] pend_a = 0;
  logic [DW-1:0] pend_w = 0;

  always @(negedge clk) begin
    if (rd_done) begin
      t_rd = cyc;
      if (exp_q.size() == 0) chk(0, "R2 unexpected rd_done", rd_data, 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R2/R6 read data", rd_data, e);
      end
    end
    if (pe_done) begin
      t_pe = cyc; pe_cnt++;
      ref_mem[pend_a[3:0]] = pend_kind ? pend_w : '1;
    end
  end

  task automatic do_read(input logic [AW-1:0] a);
    @(negedge clk);
    rd_req = 1; rd_addr = a;
    exp_q.push_back(ref_mem[a[3:0]]);
    forever begin @(negedge clk); if (rd_gnt) break; end
    rd_req = 0;
  endtask

  task automatic do_pe(input logic k, input logic [AW-1:0] a, input logic [DW-1:0] w);
    @(negedge clk);
    pend_kind = k; pend_a = a; pend_w = w;
    pe_req = 1; pe_kind = k; pe_addr = a; pe_wdata = w;
    forever begin @(negedge clk); if (pe_gnt) break; end
    pe_req = 0;
  endtask

  task automatic wait_pe(input int n);
    while (pe_cnt < n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_rd();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_log(input string req, input int n, input logic [2:0] e [8]);
    chk(log_n == n, req, log_n, n);
    for (int i = 0; i < n && i < log_n; i++)
      chk(log_op[i] == e[i], req, log_op[i], e[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin
    int base, gap;
    rst_n = 0; cfg = 0; rd_req = 0; pe_req = 0; pe_kind = 0;
    rd_addr = 0; pe_addr = 0; pe_wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!fl_start && !rd_gnt && !pe_gnt, "R1 strobes", {fl_start, rd_gnt, pe_gnt}, 0);
    chk(!rd_done && !pe_done, "R1 done", {rd_done, pe_done}, 0);
    chk(fl_op == 3'd0, "R1 fl_op", fl_op, 0);

    // R2 idle read
    cfg = 1; log_n = 0;
    do_read(3); wait_rd();
    chk_log("R2 order", 1, '{C_READ, 0, 0, 0, 0, 0, 0, 0});

    // R3 / R6 preempted erase
    log_n = 0; base = pe_cnt;
    fork
      do_pe(0, 5, 0);
      begin repeat (10) @(negedge clk); do_read(2); end
    join
    wait_pe(base + 1); wait_rd();
    chk_log("R3 order", 4, '{C_ERASE, C_SUSP, C_READ, C_RES, 0, 0, 0, 0});
    chk(t_rd < t_pe, "R3 read before pe_done", t_rd, t_pe);
    chk(pe_cnt == base + 1, "R6 single pe_done", pe_cnt, base + 1);
    chk(t_pe - log_t[0] >= ERASE_WORK, "R6 full duration", t_pe - log_t[0], ERASE_WORK);

    // R7 / R9 window cap and resume hold
    log_n = 0; base = pe_cnt;
    fork
      do_pe(1, 6, 32'h1234_5678);
      begin repeat (10) @(negedge clk); do_read(1); do_read(2); do_read(4); end
    join
    wait_pe(base + 1); wait_rd();
    chk_log("R7 order", 8, '{C_PROG, C_SUSP, C_READ, C_READ, C_RES, C_SUSP, C_READ, C_RES});
    gap = log_t[5] - log_t[4];
    chk(gap >= HOLD, "R9 hold gap", gap, HOLD);

    // R5 serialized mode
    cfg = 0; log_n = 0; base = pe_cnt;
    fork
      do_pe(0, 7, 0);
      begin repeat (10) @(negedge clk); do_read(3); end
    join
    wait_pe(base + 1); wait_rd();
    chk_log("R5 order", 2, '{C_ERASE, C_READ, 0, 0, 0, 0, 0, 0});
    chk(t_rd > t_pe, "R5 read after pe_done", t_rd, t_pe);

    // R10 simultaneous requests
    cfg = 1; log_n = 0; base = pe_cnt;
    fork
      do_pe(1, 8, 32'hCAFE_0008);
      do_read(0);
    join
    wait_pe(base + 1); wait_rd();
    chk_log("R10 order", 2, '{C_READ, C_PROG, 0, 0, 0, 0, 0, 0});

    // R6 written contents read back
    do_read(5); do_read(6); do_read(7); do_read(8); wait_rd();

    chk(viol == 0, "R4/R8 stub protocol violations", viol, 0);
    chk(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule